// File: doc/BRIEF.md
# CPU-to-PCI I/O Address Window Decoder

This block decides whether a CPU physical address belongs to a single I/O window that forwards to a PCI bus. Software programs the window through a 32-bit register write port. A base register gives the first granule of the window. A limit register gives the last granule. Each granule is 2 MB. Each base write also copies its low bits into a companion translation register. The decoder never lets the window cover two fixed address holes. When an edge of the window falls inside a hole, the decoder moves that edge out of the hole. When the window covers a whole hole, the decoder cuts the window short at the start of that hole.

A new programming takes effect only when the base granule index is not above the limit. Otherwise the decoder keeps the window it had before. The decoder holds the clipped window in registers and presents it as a start address and a length. A registered hit flag answers the question "is this CPU address inside the window".

Top module: `cpu_io_window_decoder`

## Requirements
- R1: The base register keeps write data bits 14:0. The limit register keeps write data bits 6:0. The select codes are 0 for base, 1 for limit, 2 for translation and 3 for unused. A register keeps its value in any cycle in which it is not written.
- R2: A write to base (select 0) also loads the translation register with write data bits 10:0. A write to select 2 does not change the translation register.
- R3: After reset, base reads 0x080, limit reads 0x00F and translation reads 0x080. After reset the window starts at 0x10000000 and is 0x2000000 bytes long.
- R4: The raw start is the base shifted left by 21. The raw end is the raw start plus ((limit + 1 - base[6:0]) shifted left by 21). After a clipped end E and a clipped start S, win_length reads E-S (or 0 when E <= S). win_hit is high one cycle after the address is presented, when S <= address < E.
- R5: A write to base or limit updates the window in the same clock edge as the register, but only when base[6:0] <= limit. Otherwise the previous window stays in force.
- R6: If the window end lies inside hole A = [0x1E000000, 0x1F100000) or hole B = [0x1FC00000, 0x1FD00000), the end moves down to the first address of that hole.
- R7: If the window start lies inside a hole, the start moves up to the first address after that hole. A window that lies wholly inside a hole ends up empty and never hits.
- R8: If the window starts below a hole and ends at or above its top, the end is cut to the first address of that hole. No address inside either hole ever hits.
- R9: Window bounds use 37-bit arithmetic. A window that ends at 2^36 hits at address 0xFFFFFFFFF.
- R10: rd_data is registered and shows the selected register one cycle after rd_sel. Select 3 reads zero, and all bits above each register's width read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select for write |
| cfg_wdata | input | 32 | Register write data |
| rd_sel | input | 2 | Register select for read |
| rd_data | output | 32 | Registered read data |
| cpu_addr | input | 36 | CPU physical address to decode |
| win_hit | output | 1 | Registered window hit flag |
| win_start | output | 37 | Clipped window start address |
| win_length | output | 37 | Clipped window length in bytes |

## Verification
A register write lands on the next rising edge. That same edge also refreshes win_start and win_length. The bench drives each write on a falling edge and reads the window outputs on the following falling edge. win_hit and rd_data each add one register after their input, so each probe or read holds its input for one full cycle and samples half a cycle after the capturing edge. Each vector first writes limit and then base, and checks only after the base write has settled. Any window produced by the limit write alone is therefore overwritten or kept as the requirements say before the check.

// File: rtl/cpuwin_pkg.sv
package cpuwin_pkg;

  typedef enum logic [1:0] {
    SEL_BASE  = 2'd0,
    SEL_LIMIT = 2'd1,
    SEL_XLAT  = 2'd2,
    SEL_NONE  = 2'd3
  } win_sel_e;

  // Half-open address span [bgn, fin)
  typedef struct packed {
    logic [63:0] bgn;
    logic [63:0] fin;
  } span_t;

  function automatic logic [63:0] low_bits(input logic [63:0] v, input int w);
    return v & ((64'd1 << w) - 64'd1);
  endfunction

  function automatic logic cfg_ok(input logic [63:0] base, input logic [63:0] limit,
                                  input int lim_w);
    return low_bits(base, lim_w) <= limit;
  endfunction

  function automatic span_t raw_span(input logic [63:0] base, input logic [63:0] limit,
                                     input int sh, input int lim_w);
    span_t s;
    s.bgn = base << sh;
    s.fin = s.bgn + ((limit + 64'd1 - low_bits(base, lim_w)) << sh);
    return s;
  endfunction

  // Move window edges out of two holes; order of the steps matters.
  function automatic span_t clip_span(input span_t w, input span_t ha, input span_t hb);
    logic [63:0] b;
    logic [63:0] e;
    b = w.bgn;
    e = w.fin;
    if (e >= ha.bgn && e < ha.fin) e = ha.bgn;
    if (b >= ha.bgn && b < ha.fin) b = ha.fin;
    if (e >= hb.bgn && e < hb.fin) e = hb.bgn;
    if (b >= hb.bgn && b < hb.fin) b = hb.fin;
    if (e >= ha.fin && b < ha.bgn) e = ha.bgn;
    if (e >= hb.fin && b < hb.bgn) e = hb.bgn;
    clip_span.bgn = b;
    clip_span.fin = e;
  endfunction

endpackage

// File: rtl/win_cfg_regs.sv
module win_cfg_regs
  import cpuwin_pkg::*;
#(
  parameter int BASE_W = 15,
  parameter int LIM_W  = 7,
  parameter int XL_W   = 11,
  parameter int DW     = 32,
  parameter logic [BASE_W-1:0] RST_BASE  = 15'h080,
  parameter logic [LIM_W-1:0]  RST_LIMIT = 7'h0F,
  parameter logic [XL_W-1:0]   RST_XLAT  = 11'h080
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [DW-1:0]     cfg_wdata,
  input  logic [1:0]        rd_sel,
  output logic [DW-1:0]     rd_data,
  output logic [BASE_W-1:0] base_nx,
  output logic [LIM_W-1:0]  limit_nx,
  output logic              cfg_wr
);

  logic [BASE_W-1:0] base_q;
  logic [LIM_W-1:0]  limit_q;
  logic [XL_W-1:0]   xlat_q;
  logic [DW-1:0]     rd_q;
  logic              wr_base, wr_limit;

  assign wr_base  = cfg_we && (win_sel_e'(cfg_sel) == SEL_BASE);
  assign wr_limit = cfg_we && (win_sel_e'(cfg_sel) == SEL_LIMIT);
  assign cfg_wr   = wr_base || wr_limit;
  assign base_nx  = wr_base  ? cfg_wdata[BASE_W-1:0] : base_q;
  assign limit_nx = wr_limit ? cfg_wdata[LIM_W-1:0]  : limit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= RST_BASE;
      limit_q <= RST_LIMIT;
      xlat_q  <= RST_XLAT;
    end else begin
      if (wr_base) begin
        base_q <= cfg_wdata[BASE_W-1:0];
        xlat_q <= cfg_wdata[XL_W-1:0];
      end
      if (wr_limit) limit_q <= cfg_wdata[LIM_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else begin
      unique case (win_sel_e'(rd_sel))
        SEL_BASE:  rd_q <= DW'(base_q);
        SEL_LIMIT: rd_q <= DW'(limit_q);
        SEL_XLAT:  rd_q <= DW'(xlat_q);
        default:   rd_q <= '0;
      endcase
    end
  end

  assign rd_data = rd_q;

  assert_xlat_follows_base_R2: assert property (@(posedge clk) disable iff (rst)
    wr_base |=> (xlat_q == $past(cfg_wdata[XL_W-1:0])));

  assert_base_holds_R1: assert property (@(posedge clk) disable iff (rst)
    !wr_base |=> $stable(base_q));

  assert_limit_holds_R1: assert property (@(posedge clk) disable iff (rst)
    !wr_limit |=> $stable(limit_q));

  assert_rd_upper_zero_R10: assert property (@(posedge clk) disable iff (rst)
    rd_q[DW-1:BASE_W] == '0);

endmodule

// File: rtl/win_clip.sv
module win_clip
  import cpuwin_pkg::*;
#(
  parameter int BASE_W = 15,
  parameter int LIM_W  = 7,
  parameter int GRAN_SH = 21,
  parameter int EW     = 37,
  parameter logic [EW-1:0] HA_LO = 37'h01E000000,
  parameter logic [EW-1:0] HA_HI = 37'h01F100000,
  parameter logic [EW-1:0] HB_LO = 37'h01FC00000,
  parameter logic [EW-1:0] HB_HI = 37'h01FD00000
) (
  input  logic [BASE_W-1:0] base_nx,
  input  logic [LIM_W-1:0]  limit_nx,
  output logic [EW-1:0]     cand_bgn,
  output logic [EW-1:0]     cand_fin,
  output logic              cand_ok
);

  span_t raw, clipped, ha, hb;

  always_comb begin
    ha.bgn   = 64'(HA_LO);
    ha.fin   = 64'(HA_HI);
    hb.bgn   = 64'(HB_LO);
    hb.fin   = 64'(HB_HI);
    raw      = raw_span(64'(base_nx), 64'(limit_nx), GRAN_SH, LIM_W);
    clipped  = clip_span(raw, ha, hb);
    cand_ok  = cfg_ok(64'(base_nx), 64'(limit_nx), LIM_W);
    cand_bgn = clipped.bgn[EW-1:0];
    cand_fin = clipped.fin[EW-1:0];
  end

endmodule

// File: rtl/win_hit.sv
module win_hit #(
  parameter int PA_W = 36,
  parameter int EW   = 37,
  parameter logic [EW-1:0] RST_BGN = '0,
  parameter logic [EW-1:0] RST_FIN = '0,
  parameter logic [EW-1:0] HA_LO = 37'h01E000000,
  parameter logic [EW-1:0] HA_HI = 37'h01F100000,
  parameter logic [EW-1:0] HB_LO = 37'h01FC00000,
  parameter logic [EW-1:0] HB_HI = 37'h01FD00000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            upd,
  input  logic [EW-1:0]   cand_bgn,
  input  logic [EW-1:0]   cand_fin,
  input  logic [PA_W-1:0] cpu_addr,
  output logic            hit,
  output logic [EW-1:0]   start,
  output logic [EW-1:0]   length
);

  localparam logic [EW-1:0] RST_LEN = (RST_FIN > RST_BGN) ? (RST_FIN - RST_BGN) : '0;

  logic [EW-1:0] bgn_q, fin_q, len_q;
  logic          hit_q;
  logic [EW-1:0] addr_x;

  assign addr_x = {{(EW-PA_W){1'b0}}, cpu_addr};

  always_ff @(posedge clk) begin
    if (rst) begin
      bgn_q <= RST_BGN;
      fin_q <= RST_FIN;
      len_q <= RST_LEN;
    end else if (upd) begin
      bgn_q <= cand_bgn;
      fin_q <= cand_fin;
      len_q <= (cand_fin > cand_bgn) ? (cand_fin - cand_bgn) : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) hit_q <= 1'b0;
    else     hit_q <= (addr_x >= bgn_q) && (addr_x < fin_q);
  end

  assign hit    = hit_q;
  assign start  = bgn_q;
  assign length = len_q;

  assert_map_holds_R5: assert property (@(posedge clk) disable iff (rst)
    !upd |=> ($stable(bgn_q) && $stable(fin_q) && $stable(len_q)));

  assert_no_hole_hit_R8: assert property (@(posedge clk) disable iff (rst)
    hit_q |-> !(($past(addr_x) >= HA_LO && $past(addr_x) < HA_HI) ||
                ($past(addr_x) >= HB_LO && $past(addr_x) < HB_HI)));

  assert_hit_in_window_R4: assert property (@(posedge clk) disable iff (rst)
    (hit_q && $stable(bgn_q)) |-> ($past(addr_x) >= bgn_q));

endmodule

// File: rtl/cpu_io_window_decoder.sv
module cpu_io_window_decoder
  import cpuwin_pkg::*;
#(
  parameter int PA_W    = 36,
  parameter int DW      = 32,
  parameter int BASE_W  = 15,
  parameter int LIM_W   = 7,
  parameter int XL_W    = 11,
  parameter int GRAN_SH = 21,
  parameter logic [BASE_W-1:0] RST_BASE  = 15'h080,
  parameter logic [LIM_W-1:0]  RST_LIMIT = 7'h0F,
  parameter logic [XL_W-1:0]   RST_XLAT  = 11'h080,
  parameter logic [PA_W:0] HA_LO = 37'h01E000000,
  parameter logic [PA_W:0] HA_HI = 37'h01F100000,
  parameter logic [PA_W:0] HB_LO = 37'h01FC00000,
  parameter logic [PA_W:0] HB_HI = 37'h01FD00000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_sel,
  input  logic [DW-1:0]   cfg_wdata,
  input  logic [1:0]      rd_sel,
  output logic [DW-1:0]   rd_data,
  input  logic [PA_W-1:0] cpu_addr,
  output logic            win_hit,
  output logic [PA_W:0]   win_start,
  output logic [PA_W:0]   win_length
);

  localparam int EW = PA_W + 1;
  localparam span_t HOLE_A = '{bgn: 64'(HA_LO), fin: 64'(HA_HI)};
  localparam span_t HOLE_B = '{bgn: 64'(HB_LO), fin: 64'(HB_HI)};
  localparam span_t RST_SPAN =
    clip_span(raw_span(64'(RST_BASE), 64'(RST_LIMIT), GRAN_SH, LIM_W), HOLE_A, HOLE_B);

  logic [BASE_W-1:0] base_nx;
  logic [LIM_W-1:0]  limit_nx;
  logic              cfg_wr, cand_ok;
  logic [EW-1:0]     cand_bgn, cand_fin;

  win_cfg_regs #(
    .BASE_W(BASE_W), .LIM_W(LIM_W), .XL_W(XL_W), .DW(DW),
    .RST_BASE(RST_BASE), .RST_LIMIT(RST_LIMIT), .RST_XLAT(RST_XLAT)
  ) regs_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .rd_sel(rd_sel), .rd_data(rd_data), .base_nx(base_nx), .limit_nx(limit_nx),
    .cfg_wr(cfg_wr)
  );

  win_clip #(
    .BASE_W(BASE_W), .LIM_W(LIM_W), .GRAN_SH(GRAN_SH), .EW(EW),
    .HA_LO(HA_LO), .HA_HI(HA_HI), .HB_LO(HB_LO), .HB_HI(HB_HI)
  ) clip_i (
    .base_nx(base_nx), .limit_nx(limit_nx),
    .cand_bgn(cand_bgn), .cand_fin(cand_fin), .cand_ok(cand_ok)
  );

  win_hit #(
    .PA_W(PA_W), .EW(EW),
    .RST_BGN(RST_SPAN.bgn[EW-1:0]), .RST_FIN(RST_SPAN.fin[EW-1:0]),
    .HA_LO(HA_LO), .HA_HI(HA_HI), .HB_LO(HB_LO), .HB_HI(HB_HI)
  ) hit_i (
    .clk(clk), .rst(rst), .upd(cfg_wr && cand_ok),
    .cand_bgn(cand_bgn), .cand_fin(cand_fin), .cpu_addr(cpu_addr),
    .hit(win_hit), .start(win_start), .length(win_length)
  );

endmodule

// File: tb/cpu_io_window_decoder_tb_top.sv
`timescale 1ns/1ps
module cpu_io_window_decoder_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic [1:0]  rd_sel = 2'd0;
  logic [31:0] rd_data;
  logic [35:0] cpu_addr = '0;
  logic        win_hit;
  logic [36:0] win_start, win_length;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cpu_io_window_decoder dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .rd_sel(rd_sel), .rd_data(rd_data), .cpu_addr(cpu_addr), .win_hit(win_hit),
    .win_start(win_start), .win_length(win_length)
  );

  typedef struct packed {
    logic [6:0]  lim;
    logic [14:0] base;
    logic [35:0] probe;
    logic        exp_hit;
    logic [36:0] exp_start;
    logic [36:0] exp_len;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{7'h0F, 15'h0080, 36'h011FFFFFF, 1'b1, 37'h010000000, 37'h002000000}, // R4 last byte
    '{7'h0F, 15'h0080, 36'h012000000, 1'b0, 37'h010000000, 37'h002000000}, // R4 end excl
    '{7'h0F, 15'h0080, 36'h00FFFFFFF, 1'b0, 37'h010000000, 37'h002000000}, // R4 below
    '{7'h73, 15'h00E8, 36'h01DFFFFFF, 1'b1, 37'h01D000000, 37'h001000000}, // R6
    '{7'h73, 15'h00E8, 36'h01E000000, 1'b0, 37'h01D000000, 37'h001000000}, // R6
    '{7'h7B, 15'h00F0, 36'h01F0FFFFF, 1'b0, 37'h01F100000, 37'h000700000}, // R7
    '{7'h7B, 15'h00F0, 36'h01F100000, 1'b1, 37'h01F100000, 37'h000700000}, // R7
    '{7'h78, 15'h00E0, 36'h01F180000, 1'b0, 37'h01C000000, 37'h002000000}, // R8
    '{7'h78, 15'h00E0, 36'h01DFFFFFF, 1'b1, 37'h01C000000, 37'h002000000}, // R8
    '{7'h7E, 15'h00F9, 36'h01FC80000, 1'b0, 37'h01F200000, 37'h000A00000}, // R8 hole B
    '{7'h7E, 15'h00F9, 36'h01FBFFFFF, 1'b1, 37'h01F200000, 37'h000A00000}, // R8 hole B
    '{7'h7F, 15'h00FE, 36'h01FC00000, 1'b0, 37'h01FD00000, 37'h000300000}, // R7 hole B
    '{7'h7F, 15'h00FE, 36'h01FD00000, 1'b1, 37'h01FD00000, 37'h000300000}, // R7 hole B
    '{7'h10, 15'h00A0, 36'h01FFFFFFF, 1'b1, 37'h01FD00000, 37'h000300000}, // R5 kept
    '{7'h7F, 15'h7FF0, 36'hFFFFFFFFF, 1'b1, 37'h0FFE000000, 37'h002000000}, // R9
    '{7'h7F, 15'h7FF0, 36'hFFDFFFFFF, 1'b0, 37'h0FFE000000, 37'h002000000}, // R9
    '{7'h70, 15'h00F0, 36'h01E000000, 1'b0, 37'h01F100000, 37'h000000000}  // R7 empty
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] val);
    @(negedge clk);
    rd_sel = sel;
    @(negedge clk);
    val = rd_data;
  endtask

  task automatic probe(input logic [35:0] a, output logic h);
    @(negedge clk);
    cpu_addr = a;
    @(negedge clk);
    h = win_hit;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic        h;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R3: reset register and window state
    rd(2'd0, v); chk("R3 base reset", 64'(v), 64'h080);
    rd(2'd1, v); chk("R3 limit reset", 64'(v), 64'h00F);
    rd(2'd2, v); chk("R3 xlat reset", 64'(v), 64'h080);
    rd(2'd3, v); chk("R10 unused select", 64'(v), 64'h0);
    chk("R3 start reset", 64'(win_start), 64'h010000000);
    chk("R3 length reset", 64'(win_length), 64'h002000000);
    probe(36'h010000000, h); chk("R3 reset hit", 64'(h), 64'd1);

    // Vector table: limit then base, then probe
    for (int i = 0; i < NV; i++) begin
      wr(2'd1, 32'(VECS[i].lim));
      wr(2'd0, 32'(VECS[i].base));
      probe(VECS[i].probe, h);
      chk($sformatf("R4-vec%0d hit", i), 64'(h), 64'(VECS[i].exp_hit));
      chk($sformatf("R4-vec%0d start", i), 64'(win_start), 64'(VECS[i].exp_start));
      chk($sformatf("R4-vec%0d length", i), 64'(win_length), 64'(VECS[i].exp_len));
    end

    // R1 masks, R2 translation copy and select-2 write ignored
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, v); chk("R1 limit mask", 64'(v), 64'h7F);
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, v); chk("R1 base mask", 64'(v), 64'h7FFF);
    rd(2'd2, v); chk("R2 xlat loaded", 64'(v), 64'h7FF);
    wr(2'd2, 32'h0000_0000);
    rd(2'd2, v); chk("R2 xlat write ignored", 64'(v), 64'h7FF);
    wr(2'd3, 32'h0000_0000);
    rd(2'd0, v); chk("R1 base unchanged", 64'(v), 64'h7FFF);
    rd(2'd3, v); chk("R10 unused select", 64'(v), 64'h0);
    // R9: one-granule window ending at 2^36
    chk("R9 start", 64'(win_start), 64'h0FFFE00000);
    chk("R9 length", 64'(win_length), 64'h000200000);
    probe(36'hFFFFFFFFF, h); chk("R9 top hit", 64'(h), 64'd1);

    // R5: invalid limit write keeps window
    wr(2'd1, 32'h0000_0010);
    chk("R5 start kept", 64'(win_start), 64'h0FFFE00000);
    rd(2'd1, v); chk("R5 limit stored", 64'(v), 64'h10);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule